// File: doc/BRIEF.md
# MII Management Frame Handler

This block gives software a register-mapped path to an emulated Ethernet PHY. Software writes one 32-bit frame word. In the same clock edge the block decodes the word and runs a read or a write against an internal file of 32 sixteen-bit PHY registers. It then stores the word back with its turnaround flag set, which marks completion. A read frame comes back with its data field replaced by the contents of the selected PHY register. The emulated PHY answers at one address only. A write to the basic control register (PHY register 0) with its reset or restart-negotiation bits set clears those bits and applies their side effects at once.

Alongside the frame register there is a configuration register with two read-only transceiver-select bits, a 16-bit management status register that clears when read, and a 16-bit interrupt mask. A change on the `link_up` input loads every status bit and updates the PHY's link bits. The interrupt request is raised while any status bit is set whose mask bit is clear.

Top module: `miim_frame_ctrl`

## Requirements
- R1: After reset, the register map reads as follows: frame word 0, configuration 0x0000_0100, mask 0x0000_FFFF, status 0. `mgmt_irq` is low.
- R2: A frame word whose bits 31:30 are not 01, or whose PHY address (bits 27:23) is not 1, makes no PHY access. A frame word with start 01 and PHY address 1 whose opcode (bits 29:28) is 00 or 11 also makes no access. In every such case the word is stored with bit 16 set and no other bit changed.
- R3: Opcode 01 with start 01 and PHY address 1 writes bits 15:0 into the PHY register given by bits 22:18. The stored word is the written word with bit 16 set.
- R4: Opcode 10 with start 01 and PHY address 1 stores the written word with bit 16 set and bits 15:0 replaced by the selected PHY register's value taken before that edge.
- R5: A write to PHY register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R6: A write to PHY register 0 with bit 9 set stores it with bit 9 cleared and sets bit 5 of PHY register 1. If `link_up` is high it also sets bit 2 of register 1 and bit 8 of register 5.
- R7: Configuration bits 9:8 keep their value on writes. All other configuration bits take the written value.
- R8: Reading the status register returns its current value and clears it at the same edge. Writes to the status offset have no effect.
- R9: When `link_up` differs from its value in the previous cycle, status is loaded with 0xFFFF, and bit 2 of PHY register 1 and bit 8 of PHY register 5 take the new `link_up` level. This load takes priority over a clearing read in the same cycle.
- R10: `mgmt_irq` is high exactly when some status bit is 1 while the same mask bit is 0.
- R11: After reset, PHY register 1 is 0x4028 plus bit 2 if `link_up` is high, register 4 is 0x0100, register 5 is 0x0100 if `link_up` is high and 0 otherwise, and every other PHY register is 0.
- R12: Offsets are 0 frame, 1 configuration, 2 mask, 3 status. `bus_rdata` takes the selected value one edge after a cycle with `bus_rd` high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| link_up | input | 1 | Link level from the line side |
| mgmt_irq | output | 1 | Management interrupt request |

## Verification
The hardest case to reach from the ports is a status-clearing read in the same cycle as a link edge, together with a restart-negotiation write that meets a link change. Both rules act on the same status and PHY bits. The stimulus drives the read strobe and the new `link_up` level on the same falling edge. It then reads PHY registers 1 and 5 back through read frames to see which rule won. The bench first clears registers 1 and 5 through write frames, so the restart side effects are seen starting from zero.

// File: rtl/miim_pkg.sv
package miim_pkg;

  localparam int FW_W        = 32;
  localparam int FW_ST_LO    = 30;
  localparam int FW_OP_LO    = 28;
  localparam int FW_PHY_LO   = 23;
  localparam int FW_REG_LO   = 18;
  localparam int FW_TA_BIT   = 16;
  localparam int FW_FLD_W    = 5;

  localparam int PR_CTRL     = 0;
  localparam int PR_STAT     = 1;
  localparam int PR_ADV      = 4;
  localparam int PR_PARTNER  = 5;

  localparam int CTRL_RESET   = 15;
  localparam int CTRL_ANEN    = 12;
  localparam int CTRL_RESTART = 9;
  localparam int STAT_100FD   = 14;
  localparam int STAT_ANDONE  = 5;
  localparam int STAT_ANABLE  = 3;
  localparam int STAT_LINK    = 2;
  localparam int ABIL_100FD   = 8;

  typedef enum logic [1:0] {
    OP_IDLE0 = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_IDLE3 = 2'b11
  } mii_op_e;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  function automatic logic [1:0] fw_start(input logic [FW_W-1:0] w);
    return w[FW_ST_LO +: 2];
  endfunction

  function automatic mii_op_e fw_op(input logic [FW_W-1:0] w);
    return mii_op_e'(w[FW_OP_LO +: 2]);
  endfunction

  function automatic logic [FW_FLD_W-1:0] fw_phy(input logic [FW_W-1:0] w);
    return w[FW_PHY_LO +: FW_FLD_W];
  endfunction

  function automatic logic [FW_FLD_W-1:0] fw_reg(input logic [FW_W-1:0] w);
    return w[FW_REG_LO +: FW_FLD_W];
  endfunction

  // Control register value as stored after self-clearing bits are applied
  function automatic logic [15:0] ctrl_store(input logic [15:0] d);
    logic [15:0] v;
    v = d;
    if (v[CTRL_RESET]) begin
      v[CTRL_RESET] = 1'b0;
      v[CTRL_ANEN]  = 1'b1;
    end
    v[CTRL_RESTART] = 1'b0;
    return v;
  endfunction

  // Power-on contents of one PHY register
  function automatic logic [15:0] phy_init(input int idx, input logic link);
    logic [15:0] v;
    v = '0;
    case (idx)
      PR_STAT: begin
        v[STAT_100FD]  = 1'b1;
        v[STAT_ANDONE] = 1'b1;
        v[STAT_ANABLE] = 1'b1;
        v[STAT_LINK]   = link;
      end
      PR_ADV:     v[ABIL_100FD] = 1'b1;
      PR_PARTNER: v[ABIL_100FD] = link;
      default:    v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/miim_frame_exec.sv
module miim_frame_exec
  import miim_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_AW   = 5,
  parameter logic [FW_FLD_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic              frame_wr,
  input  logic [FW_W-1:0]   wdata,
  input  logic [DATA_W-1:0] phy_rd_data,
  output logic [REG_AW-1:0] phy_rd_addr,
  output logic              phy_wr_en,
  output logic [REG_AW-1:0] phy_wr_addr,
  output logic [DATA_W-1:0] phy_wr_data,
  output logic              access_ok,
  output logic [FW_W-1:0]   frame_next
);

  mii_op_e op;

  always_comb begin
    op          = fw_op(wdata);
    access_ok   = (fw_start(wdata) == 2'b01) && (fw_phy(wdata) == PHY_ADDR);
    phy_rd_addr = REG_AW'(fw_reg(wdata));
    phy_wr_addr = REG_AW'(fw_reg(wdata));
    phy_wr_data = wdata[DATA_W-1:0];
    phy_wr_en   = frame_wr && access_ok && (op == OP_WRITE);
    frame_next  = wdata;
    frame_next[FW_TA_BIT] = 1'b1;
    if (access_ok && op == OP_READ) frame_next[DATA_W-1:0] = phy_rd_data;
  end

endmodule

// File: rtl/miim_phy_regs.sv
module miim_phy_regs
  import miim_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 16,
  localparam int REG_AW  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_now,
  input  logic              link_evt,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic restart_evt;
  logic [DATA_W-1:0] ctrl_q, stat_q;

  assign restart_evt = wr_en && (wr_addr == REG_AW'(PR_CTRL)) && wr_data[CTRL_RESTART];
  assign ctrl_q  = regs[PR_CTRL];
  assign stat_q  = regs[PR_STAT];
  assign rd_data = regs[rd_addr];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
    logic [DATA_W-1:0] q, nxt;
    always_comb begin
      nxt = q;
      if (wr_en && wr_addr == REG_AW'(gi))
        nxt = (gi == PR_CTRL) ? ctrl_store(wr_data) : wr_data;
      if (gi == PR_STAT) begin
        if (restart_evt) begin
          nxt[STAT_ANDONE] = 1'b1;
          if (link_now) nxt[STAT_LINK] = 1'b1;
        end
        if (link_evt) nxt[STAT_LINK] = link_now;
      end
      if (gi == PR_PARTNER) begin
        if (restart_evt && link_now) nxt[ABIL_100FD] = 1'b1;
        if (link_evt) nxt[ABIL_100FD] = link_now;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q <= phy_init(gi, link_now);
      else        q <= nxt;
    end
    assign regs[gi] = q;
  end

  assert_ctrl_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_AW'(PR_CTRL)) |=> (!ctrl_q[CTRL_RESET] && !ctrl_q[CTRL_RESTART]));
  assert_ctrl_anen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_AW'(PR_CTRL) && wr_data[CTRL_RESET]) |=> ctrl_q[CTRL_ANEN]);
  assert_restart_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> stat_q[STAT_ANDONE]);
  assert_link_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> (stat_q[STAT_LINK] == $past(link_now)));

endmodule

// File: rtl/miim_irq_ctrl.sv
module miim_irq_ctrl #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] mask_wdata,
  input  logic              stat_rd,
  input  logic              link_evt,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (link_evt)     stat_q <= '1;
      else if (stat_rd) stat_q <= '0;
    end
  end

  assign irq = |(stat_q & ~mask_q);

  assert_status_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> (stat_q == '1));
  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !link_evt) |=> (stat_q == '0));
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(link_evt) || $past(mask_wr)));

endmodule

// File: rtl/miim_frame_ctrl.sv
module miim_frame_ctrl
  import miim_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 16,
  parameter logic [FW_FLD_W-1:0] PHY_ADDR = 5'd1,
  parameter logic [FW_W-1:0] CFG_RO_MASK  = 32'h0000_0300,
  parameter logic [FW_W-1:0] CFG_INIT     = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [FW_W-1:0] bus_wdata,
  output logic [FW_W-1:0] bus_rdata,
  input  logic            link_up,
  output logic            mgmt_irq
);

  localparam int REG_AW = $clog2(NUM_REGS);

  reg_sel_e sel;
  logic [FW_W-1:0]   frame_q, cfg_q, frame_next;
  logic              link_q, link_evt;
  logic              frame_wr, cfg_wr, mask_wr, stat_rd, access_ok;
  logic [REG_AW-1:0] phy_rd_addr, phy_wr_addr;
  logic [DATA_W-1:0] phy_rd_data, phy_wr_data, mask_q, stat_q;
  logic              phy_wr_en;

  assign sel      = reg_sel_e'(bus_addr);
  assign frame_wr = bus_wr && sel == SEL_FRAME;
  assign cfg_wr   = bus_wr && sel == SEL_CFG;
  assign mask_wr  = bus_wr && sel == SEL_MASK;
  assign stat_rd  = bus_rd && sel == SEL_STAT;
  assign link_evt = link_up != link_q;

  miim_frame_exec #(.DATA_W(DATA_W), .REG_AW(REG_AW), .PHY_ADDR(PHY_ADDR)) u_exec (
    .frame_wr(frame_wr), .wdata(bus_wdata), .phy_rd_data(phy_rd_data),
    .phy_rd_addr(phy_rd_addr), .phy_wr_en(phy_wr_en), .phy_wr_addr(phy_wr_addr),
    .phy_wr_data(phy_wr_data), .access_ok(access_ok), .frame_next(frame_next)
  );

  miim_phy_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_phy (
    .clk(clk), .rst_n(rst_n), .link_now(link_up), .link_evt(link_evt),
    .rd_addr(phy_rd_addr), .rd_data(phy_rd_data),
    .wr_en(phy_wr_en), .wr_addr(phy_wr_addr), .wr_data(phy_wr_data)
  );

  miim_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(bus_wdata[DATA_W-1:0]),
    .stat_rd(stat_rd), .link_evt(link_evt), .mask_q(mask_q), .stat_q(stat_q),
    .irq(mgmt_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q   <= '0;
      cfg_q     <= CFG_INIT;
      link_q    <= link_up;
      bus_rdata <= '0;
    end else begin
      link_q <= link_up;
      if (frame_wr) frame_q <= frame_next;
      if (cfg_wr)   cfg_q   <= (bus_wdata & ~CFG_RO_MASK) | (cfg_q & CFG_RO_MASK);
      if (bus_rd) begin
        case (sel)
          SEL_FRAME: bus_rdata <= frame_q;
          SEL_CFG:   bus_rdata <= cfg_q;
          SEL_MASK:  bus_rdata <= FW_W'(mask_q);
          default:   bus_rdata <= FW_W'(stat_q);
        endcase
      end
    end
  end

  assert_ta_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |=> frame_q[FW_TA_BIT]);
  assert_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && !access_ok) |-> !phy_wr_en);
  assert_cfg_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ((cfg_q & CFG_RO_MASK) == $past(cfg_q & CFG_RO_MASK)));

endmodule

// File: tb/miim_frame_ctrl_test.sv
`timescale 1ns/1ps
module miim_frame_ctrl_test;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, link_up = 1;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        mgmt_irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  miim_frame_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .link_up(link_up), .mgmt_irq(mgmt_irq)
  );

  // Behavioural reference model
  logic [15:0] m_phy [32];
  logic [31:0] m_frame, m_cfg, m_rdata;
  logic [15:0] m_mask, m_stat;
  logic        m_link, m_live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_phy[i] = 16'h0;
      m_phy[1] = 16'h4028 | (link_up ? 16'h0004 : 16'h0);
      m_phy[4] = 16'h0100;
      m_phy[5] = link_up ? 16'h0100 : 16'h0;
      m_frame = 0; m_cfg = 32'h100; m_rdata = 0; m_mask = 16'hFFFF; m_stat = 0;
      m_link = link_up; m_live = 1;
    end else begin
      logic [31:0] w; logic [15:0] d; logic evt; int r;
      evt = (link_up != m_link);
      if (bus_rd) begin
        if (bus_addr == 0) m_rdata = m_frame;
        else if (bus_addr == 1) m_rdata = m_cfg;
        else if (bus_addr == 2) m_rdata = {16'h0, m_mask};
        else begin m_rdata = {16'h0, m_stat}; m_stat = 0; end
      end
      if (bus_wr) begin
        if (bus_addr == 0) begin
          w = bus_wdata; r = int'(w[22:18]);
          if (w[31:30] == 2'b01 && w[27:23] == 5'd1) begin
            if (w[29:28] == 2'b01) begin
              d = w[15:0];
              if (r == 0) begin
                if (d & 16'h8000) d = (d & ~16'h8000) | 16'h1000;
                if (d & 16'h0200) begin
                  d = d & ~16'h0200;
                  m_phy[1] = m_phy[1] | 16'h0020;
                  if (link_up) begin
                    m_phy[1] = m_phy[1] | 16'h0004;
                    m_phy[5] = m_phy[5] | 16'h0100;
                  end
                end
              end
              m_phy[r] = d;
            end else if (w[29:28] == 2'b10) begin
              w = {w[31:16], m_phy[r]};
            end
          end
          m_frame = w | 32'h0001_0000;
        end else if (bus_addr == 1) begin
          m_cfg = (bus_wdata & ~32'h300) | (m_cfg & 32'h300);
        end else if (bus_addr == 2) begin
          m_mask = bus_wdata[15:0];
        end
      end
      if (evt) begin
        m_stat = 16'hFFFF;
        m_phy[1] = link_up ? (m_phy[1] | 16'h0004) : (m_phy[1] & ~16'h0004);
        m_phy[5] = link_up ? (m_phy[5] | 16'h0100) : (m_phy[5] & ~16'h0100);
      end
      m_link = link_up;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (m_live) begin
      checks++;
      if (bus_rdata !== m_rdata || mgmt_irq !== ((m_stat & ~m_mask) != 0)) begin
        errors++;
        $display("FAIL %s model compare: rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, bus_rdata, mgmt_irq, m_rdata, (m_stat & ~m_mask) != 0);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  function automatic logic [31:0] fw(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] r,
                                     input logic [15:0] d);
    return {st, op, phy, r, 2'b00, d};
  endfunction

  task automatic phy_get(input logic [4:0] r, output logic [15:0] v);
    logic [31:0] f;
    wr(0, fw(2'b01, 2'b10, 5'd1, r, 16'h0));
    rd(0, f);
    v = f[15:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v; logic [15:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state and R12 map
    cur_req = "R1";
    rd(0, v); check("R1 frame", v, 32'h0);
    rd(1, v); check("R1 cfg", v, 32'h100);
    rd(2, v); check("R1 mask", v, 32'hFFFF);
    rd(3, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'h0, mgmt_irq}, 32'h0);
    // R11 PHY reset values with link up
    cur_req = "R11";
    phy_get(1, p); check("R11 reg1", {16'h0, p}, 32'h402C);
    phy_get(4, p); check("R11 reg4", {16'h0, p}, 32'h0100);
    phy_get(5, p); check("R11 reg5", {16'h0, p}, 32'h0100);
    phy_get(9, p); check("R11 reg9", {16'h0, p}, 32'h0);
    // R4 full read frame word
    cur_req = "R4";
    wr(0, fw(2'b01, 2'b10, 5'd1, 5'd1, 16'h1234)); rd(0, v);
    check("R4 read frame", v, 32'h6085_402C);
    // R3 write then read back
    cur_req = "R3";
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd7, 16'hBEEF)); rd(0, v);
    check("R3 stored word", v, 32'h509D_BEEF);
    phy_get(7, p); check("R3 reg7", {16'h0, p}, 32'hBEEF);
    // R2 rejected frames
    cur_req = "R2";
    wr(0, fw(2'b10, 2'b01, 5'd1, 5'd7, 16'h1111)); rd(0, v);
    check("R2 bad start word", v, 32'h909D_1111);
    wr(0, fw(2'b01, 2'b01, 5'd2, 5'd7, 16'h2222));
    wr(0, fw(2'b01, 2'b11, 5'd1, 5'd7, 16'h3333)); rd(0, v);
    check("R2 opcode 11 word", v, 32'h709D_3333);
    wr(0, fw(2'b01, 2'b10, 5'd3, 5'd7, 16'h4444)); rd(0, v);
    check("R2 read other phy", v, 32'h619D_4444);
    phy_get(7, p); check("R2 reg7 untouched", {16'h0, p}, 32'hBEEF);
    // R5 control reset bit
    cur_req = "R5";
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd0, 16'h8123));
    phy_get(0, p); check("R5 ctrl", {16'h0, p}, 32'h1123);
    // R6 restart with link down then up
    cur_req = "R6";
    @(negedge clk); link_up = 0; @(negedge clk);
    rd(3, v);
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd1, 16'h0));
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd5, 16'h0));
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200));
    phy_get(0, p); check("R6 ctrl bit9 clear", {16'h0, p}, 32'h0);
    phy_get(1, p); check("R6 reg1 link down", {16'h0, p}, 32'h0020);
    phy_get(5, p); check("R6 reg5 link down", {16'h0, p}, 32'h0);
    @(negedge clk); link_up = 1; @(negedge clk);
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd1, 16'h0));
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd5, 16'h0));
    wr(0, fw(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200));
    phy_get(1, p); check("R6 reg1 link up", {16'h0, p}, 32'h0024);
    phy_get(5, p); check("R6 reg5 link up", {16'h0, p}, 32'h0100);
    // R7 configuration read-only bits
    cur_req = "R7";
    wr(1, 32'hFFFF_FCFF); rd(1, v); check("R7 cfg ones", v, 32'hFFFF_FDFF);
    wr(1, 32'h0); rd(1, v); check("R7 cfg zero", v, 32'h0000_0100);
    // R8 clear on read, write ignored
    cur_req = "R8";
    rd(3, v); check("R8 first read", v, 32'hFFFF);
    rd(3, v); check("R8 cleared", v, 32'h0);
    wr(3, 32'h0000_5555); rd(3, v); check("R8 write ignored", v, 32'h0);
    // R9 link change, and priority over a same-cycle read
    cur_req = "R9";
    @(negedge clk); link_up = 0; bus_rd = 1; bus_addr = 3;
    @(negedge clk); bus_rd = 0; check("R9 old value on read", bus_rdata, 32'h0);
    rd(3, v); check("R9 load wins", v, 32'hFFFF);
    phy_get(1, p); check("R9 link bit down", {16'h0, p}, 32'h0020);
    phy_get(5, p); check("R9 partner bit down", {16'h0, p}, 32'h0);
    // R10 interrupt masking
    cur_req = "R10";
    @(negedge clk); link_up = 1; @(negedge clk);
    check("R10 masked irq", {31'h0, mgmt_irq}, 32'h0);
    wr(2, 32'h0000_FFFE); check("R10 unmasked irq", {31'h0, mgmt_irq}, 32'h1);
    rd(3, v); check("R10 irq after clear", {31'h0, mgmt_irq}, 32'h0);
    // R12 read data holds between reads
    cur_req = "R12";
    rd(2, v); repeat (4) @(negedge clk);
    check("R12 hold", bus_rdata, 32'h0000_FFFE);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule